// File: doc/BRIEF.md
# Inter-Access Bus Idle Gap Inserter

This block sits inside an external memory bus controller, between a stream of access requests and the chip-select outputs. Each request carries a chip-select index and a read/write flag. The requester holds a request with `req_valid` until `req_ready` rises. Before it launches a request, the block works out how many idle bus cycles must separate that access from the one before it. It raises `idle_strobe` for that many cycles and only then drives the chip select.

The gap is not one fixed turnaround. It is the largest of four terms, all 3-bit unsigned:
- the programmed minimum idle count of the previous space;
- a term from that space's wait-enable and chip-select negation extension;
- a saturating sum of three internal contributions (an after-read cycle, a clock-ratio term and a loop-overhead term);
- a configurable term for the read/write pair of the two accesses.

On write followed by write, a write buffer absorbs the internal contributions.

Top module: `idle_gap_inserter`

## Requirements
- R1: The gap equals the maximum of four terms: `cfg_idle_min` of the previous space, the wait/negation term, the internal sum, and the pair term. The field of space n sits at bits [3n+2:3n].
- R2: The internal sum adds 1 when the previous access was a read. It also adds `int_sync` and `int_extra`.
- R3: When a write follows a write, the internal sum counts as 0, whatever `int_sync` and `int_extra` hold.
- R4: The pair term is chosen by {previous write, next write}: 00 selects `pair_rr`, 01 `pair_rw`, 11 `pair_ww` and 10 `pair_wr`.
- R5: With the idle, wait, negation, sync and extra fields at 0, and pair terms of RR=0, RW=2, WW=0, WR=4, the gaps are 1 for R→R, 2 for R→W, 0 for W→W and 4 for W→R.
- R6: The internal sum saturates at 7 before the maximum is taken, so no gap exceeds 7.
- R7: The first access after reset gets no idle cycles. The previous access type and space are recorded only when a handshake completes.
- R8: `idle_strobe` is high for exactly the gap count of consecutive cycles, and during that time `bus_cs` is all zero and `req_ready` is low. In the next cycle `req_ready` rises together with a one-hot `bus_cs` at bit `req_cs` and with `bus_write` equal to `req_write`.
- R9: Synchronous active-high reset clears `req_ready`, `idle_strobe`, `bus_cs` and `bus_write`.
- R10: The wait/negation term is the previous space's `cfg_wait_en` bit plus its 2-bit `cfg_neg_ext` field (bits [2n+1:2n]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until accepted |
| req_ready | output | 1 | Access issued this cycle; handshake completes |
| req_cs | input | 2 | Chip-select index of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_idle_min | input | 12 | Per-space minimum idle count, 3 bits each |
| cfg_wait_en | input | 4 | Per-space wait-input enable |
| cfg_neg_ext | input | 8 | Per-space chip-select negation extension, 2 bits each |
| pair_rr | input | 3 | Device-pair term, read then read |
| pair_rw | input | 3 | Device-pair term, read then write |
| pair_ww | input | 3 | Device-pair term, write then write |
| pair_wr | input | 3 | Device-pair term, write then read |
| int_sync | input | 3 | Internal clock-ratio contribution |
| int_extra | input | 3 | Internal loop-overhead contribution |
| idle_strobe | output | 1 | High during each inserted idle cycle |
| bus_cs | output | 4 | One-hot active-high chip select while issuing |
| bus_write | output | 1 | Direction of the issued access |

## Verification
The write-buffer suppression and the saturation of the internal sum can both apply in one decision. A write after a write is sent with `int_sync` and `int_extra` set high enough to overflow 3 bits. The bench expects the pair term alone; a wrapped or unsuppressed sum would show up as a longer gap. In the same way, the after-read term and a large programmed idle count meet on one read-to-read decision. The bench then expects the larger of the two and not their sum.

// File: rtl/idlegap_pkg.sv
package idlegap_pkg;
  localparam int TERM_W = 3;
  localparam int NEG_W  = 2;

  typedef logic [TERM_W-1:0] term_t;

  typedef enum logic [1:0] {
    PH_LISTEN = 2'd0,
    PH_GAP    = 2'd1,
    PH_ISSUE  = 2'd2
  } phase_t;

  function automatic term_t sat_add(input term_t a, input term_t b);
    logic [TERM_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[TERM_W] ? '1 : s[TERM_W-1:0];
  endfunction

  function automatic term_t max2(input term_t a, input term_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ig_term_calc.sv
module ig_term_calc
  import idlegap_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                  prev_valid,
  input  logic                  prev_write,
  input  logic [CSW-1:0]        prev_cs,
  input  logic                  next_write,
  input  logic [NCS*TERM_W-1:0] cfg_idle_min,
  input  logic [NCS-1:0]        cfg_wait_en,
  input  logic [NCS*NEG_W-1:0]  cfg_neg_ext,
  input  term_t                 pair_rr,
  input  term_t                 pair_rw,
  input  term_t                 pair_ww,
  input  term_t                 pair_wr,
  input  term_t                 int_sync,
  input  term_t                 int_extra,
  output term_t                 gap
);
  term_t idle_arr [NCS];
  term_t wn_arr   [NCS];

  for (genvar g = 0; g < NCS; g++) begin : g_space
    assign idle_arr[g] = cfg_idle_min[g*TERM_W +: TERM_W];
    assign wn_arr[g]   = sat_add(term_t'(cfg_wait_en[g]),
                                 term_t'(cfg_neg_ext[g*NEG_W +: NEG_W]));
  end

  term_t t_idle, t_wn, t_inner, t_pair, read_t, sum1, sum2;

  always_comb begin
    t_idle = idle_arr[prev_cs];
    t_wn   = wn_arr[prev_cs];
    read_t = prev_write ? term_t'(0) : term_t'(1);
    sum1   = sat_add(read_t, int_sync);
    sum2   = sat_add(sum1, int_extra);
    t_inner = (prev_write && next_write) ? term_t'(0) : sum2;
    unique case ({prev_write, next_write})
      2'b00:   t_pair = pair_rr;
      2'b01:   t_pair = pair_rw;
      2'b11:   t_pair = pair_ww;
      default: t_pair = pair_wr;
    endcase
    gap = prev_valid ? max2(max2(t_idle, t_wn), max2(t_inner, t_pair)) : term_t'(0);
  end
endmodule

// File: rtl/ig_idle_count.sv
module ig_idle_count
  import idlegap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  term_t load_val,
  input  logic  tick,
  output logic  last
);
  term_t cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= cnt - term_t'(1);
    end
  end

  assign last = (cnt == term_t'(1));
endmodule

// File: rtl/ig_issue_fsm.sv
module ig_issue_fsm
  import idlegap_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [CSW-1:0] req_cs,
  input  logic           req_write,
  input  term_t          gap,
  input  logic           cnt_last,
  output logic           cnt_load,
  output logic           cnt_tick,
  output logic           req_ready,
  output logic           idle_strobe,
  output logic [NCS-1:0] bus_cs,
  output logic           bus_write
);
  phase_t         phase;
  logic [NCS-1:0] dec;

  for (genvar g = 0; g < NCS; g++) begin : g_dec
    assign dec[g] = (req_cs == CSW'(g));
  end

  assign cnt_load = (phase == PH_LISTEN) && req_valid && (gap != '0);
  assign cnt_tick = (phase == PH_GAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_LISTEN;
      req_ready   <= 1'b0;
      idle_strobe <= 1'b0;
      bus_cs      <= '0;
      bus_write   <= 1'b0;
    end else begin
      unique case (phase)
        PH_LISTEN: begin
          if (req_valid) begin
            if (gap == '0) begin
              phase     <= PH_ISSUE;
              req_ready <= 1'b1;
              bus_cs    <= dec;
              bus_write <= req_write;
            end else begin
              phase       <= PH_GAP;
              idle_strobe <= 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (cnt_last) begin
            phase       <= PH_ISSUE;
            idle_strobe <= 1'b0;
            req_ready   <= 1'b1;
            bus_cs      <= dec;
            bus_write   <= req_write;
          end
        end
        default: begin
          if (req_valid) begin
            phase     <= PH_LISTEN;
            req_ready <= 1'b0;
            bus_cs    <= '0;
            bus_write <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idlegap_pkg::*;
#(
  parameter int NCS = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [CSW-1:0]        req_cs,
  input  logic                  req_write,
  input  logic [NCS*TERM_W-1:0] cfg_idle_min,
  input  logic [NCS-1:0]        cfg_wait_en,
  input  logic [NCS*NEG_W-1:0]  cfg_neg_ext,
  input  logic [TERM_W-1:0]     pair_rr,
  input  logic [TERM_W-1:0]     pair_rw,
  input  logic [TERM_W-1:0]     pair_ww,
  input  logic [TERM_W-1:0]     pair_wr,
  input  logic [TERM_W-1:0]     int_sync,
  input  logic [TERM_W-1:0]     int_extra,
  output logic                  idle_strobe,
  output logic [NCS-1:0]        bus_cs,
  output logic                  bus_write
);
  logic           prev_valid, prev_write;
  logic [CSW-1:0] prev_cs;
  term_t          gap;
  logic           cnt_load, cnt_tick, cnt_last;

  // history is updated only on a completed handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_write <= 1'b0;
      prev_cs    <= '0;
    end else if (req_ready && req_valid) begin
      prev_valid <= 1'b1;
      prev_write <= req_write;
      prev_cs    <= req_cs;
    end
  end

  ig_term_calc #(.NCS(NCS)) u_calc (
    .prev_valid  (prev_valid),
    .prev_write  (prev_write),
    .prev_cs     (prev_cs),
    .next_write  (req_write),
    .cfg_idle_min(cfg_idle_min),
    .cfg_wait_en (cfg_wait_en),
    .cfg_neg_ext (cfg_neg_ext),
    .pair_rr     (pair_rr),
    .pair_rw     (pair_rw),
    .pair_ww     (pair_ww),
    .pair_wr     (pair_wr),
    .int_sync    (int_sync),
    .int_extra   (int_extra),
    .gap         (gap)
  );

  ig_idle_count u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (cnt_load),
    .load_val(gap),
    .tick    (cnt_tick),
    .last    (cnt_last)
  );

  ig_issue_fsm #(.NCS(NCS)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_cs     (req_cs),
    .req_write  (req_write),
    .gap        (gap),
    .cnt_last   (cnt_last),
    .cnt_load   (cnt_load),
    .cnt_tick   (cnt_tick),
    .req_ready  (req_ready),
    .idle_strobe(idle_strobe),
    .bus_cs     (bus_cs),
    .bus_write  (bus_write)
  );
endmodule

// File: rtl/ig_checker.sv
module ig_checker #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           idle_strobe,
  input logic [NCS-1:0] bus_cs,
  input logic           bus_write
);
  logic [3:0] idle_run;

  always_ff @(posedge clk) begin
    if (rst)              idle_run <= '0;
    else if (idle_strobe) idle_run <= idle_run + 4'd1;
    else                  idle_run <= '0;
  end

  // R8: idle cycles keep the bus and the requester quiet
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    idle_strobe |-> (bus_cs == '0) && !req_ready);

  // R8: at most one chip select at a time
  assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_cs));

  // R8: an issued access drives exactly one chip select
  assert_issue_cs_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> $countones(bus_cs) == 1);

  // R8: an accepted access lasts one cycle
  assert_issue_single_R8: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid) |=> !req_ready);

  // R8: writes are signalled only with a chip select
  assert_write_with_cs_R8: assert property (@(posedge clk) disable iff (rst)
    bus_write |-> bus_cs != '0);

  // R6: no idle run longer than seven cycles
  assert_gap_cap_R6: assert property (@(posedge clk) disable iff (rst)
    idle_run <= 4'd7);

  // R9: outputs come out of reset cleared
  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !req_ready && !idle_strobe && (bus_cs == '0) && !bus_write);
endmodule

bind idle_gap_inserter ig_checker #(.NCS(NCS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .idle_strobe(idle_strobe),
  .bus_cs     (bus_cs),
  .bus_write  (bus_write)
);

// File: tb/idle_gap_inserter_test.sv
module idle_gap_inserter_test;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_cs = '0;
  logic        req_write = 1'b0;
  logic [11:0] cfg_idle_min = '0;
  logic [3:0]  cfg_wait_en = '0;
  logic [7:0]  cfg_neg_ext = '0;
  logic [2:0]  pair_rr = 3'd0, pair_rw = 3'd2, pair_ww = 3'd0, pair_wr = 3'd4;
  logic [2:0]  int_sync = '0, int_extra = '0;
  logic        idle_strobe;
  logic [3:0]  bus_cs;
  logic        bus_write;

  int checks = 0;
  int failures = 0;
  bit m_has_prev = 0;
  bit m_prev_wr = 0;
  int m_prev_cs = 0;

  always #5 clk = ~clk;

  idle_gap_inserter #(.NCS(NCS)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_write(req_write), .cfg_idle_min(cfg_idle_min),
    .cfg_wait_en(cfg_wait_en), .cfg_neg_ext(cfg_neg_ext),
    .pair_rr(pair_rr), .pair_rw(pair_rw), .pair_ww(pair_ww), .pair_wr(pair_wr),
    .int_sync(int_sync), .int_extra(int_extra), .idle_strobe(idle_strobe),
    .bus_cs(bus_cs), .bus_write(bus_write)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // reference rule for the gap, from the requirements
  function automatic int model_gap(input bit wr);
    int t_idle, t_wn, t_in, t_pair;
    if (!m_has_prev) return 0;
    t_idle = int'(cfg_idle_min[m_prev_cs*3 +: 3]);
    t_wn   = int'(cfg_wait_en[m_prev_cs]) + int'(cfg_neg_ext[m_prev_cs*2 +: 2]);
    if (m_prev_wr && wr) t_in = 0;
    else t_in = (m_prev_wr ? 0 : 1) + int'(int_sync) + int'(int_extra);
    if (t_in > 7) t_in = 7;
    case ({m_prev_wr, wr})
      2'b00:   t_pair = int'(pair_rr);
      2'b01:   t_pair = int'(pair_rw);
      2'b11:   t_pair = int'(pair_ww);
      default: t_pair = int'(pair_wr);
    endcase
    return imax(imax(t_idle, t_wn), imax(t_in, t_pair));
  endfunction

  task automatic access(input int cs, input bit wr, input int exp, input string req);
    int seen = 0;
    int guard = 0;
    req_cs = 2'(cs);
    req_write = wr;
    req_valid = 1'b1;
    forever begin
      @(negedge clk);
      guard++;
      if (idle_strobe) begin
        seen++;
        check(bus_cs == '0 && !req_ready, "R8 idle quiet", int'(bus_cs), 0);
      end
      if (req_ready) begin
        check(seen == exp, req, seen, exp);
        check(bus_cs == 4'(1 << cs), "R8 chip select", int'(bus_cs), 1 << cs);
        check(bus_write == wr, "R8 direction", int'(bus_write), int'(wr));
        @(posedge clk);
        m_has_prev = 1;
        m_prev_wr = wr;
        m_prev_cs = cs;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R8 single issue", int'(req_ready), 0);
        break;
      end
      if (guard > 40) begin
        check(1'b0, "R8 issue timeout", seen, exp);
        req_valid = 1'b0;
        break;
      end
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!req_ready && !idle_strobe && bus_cs == '0 && !bus_write,
          "R9 reset state", int'({req_ready, idle_strobe, bus_cs}), 0);

    // R7: first access after reset has no gap
    access(1, 0, 0, "R7 first access gap");
    // R5 default sequence: read, read, write, write, read, read
    access(1, 0, 1, "R5 R2 read to read gap");
    access(2, 1, 2, "R5 R4 read to write gap");
    access(2, 1, 0, "R5 R3 write to write gap");
    access(1, 0, 4, "R5 R4 write to read gap");
    access(1, 0, 1, "R5 read to read again");

    // R1: programmed idle of the previous space dominates the read term
    cfg_idle_min = 12'(5 << 3);
    access(1, 0, 5, "R1 idle minimum gap");
    check(model_gap(0) == 5, "R1 model idle", model_gap(0), 5);
    cfg_idle_min = '0;
    access(1, 0, model_gap(0), "R1 idle cleared");

    // R10: wait enable plus negation extension of the previous space
    cfg_wait_en = 4'b0010;
    cfg_neg_ext = 8'b0000_1000;
    access(1, 0, 3, "R10 wait and negation gap");
    cfg_wait_en = '0;
    cfg_neg_ext = '0;

    // R2: internal contributions add up
    int_extra = 3'd3;
    access(1, 0, 4, "R2 read plus extra gap");
    access(2, 1, 4, "R2 R1 internal beats pair");
    // R3: write buffer hides internal terms, with an overflowing sum as well
    int_sync = 3'd6;
    int_extra = 3'd7;
    access(2, 1, 0, "R3 write buffer suppression");
    // R6: saturated sum
    access(0, 0, 7, "R6 write to read saturation");
    access(0, 0, 7, "R6 read to read saturation");
    int_sync = '0;
    int_extra = '0;

    // R4: pair selection on the read-read slot
    pair_rr = 3'd6;
    access(3, 0, 6, "R4 pair read to read");
    pair_ww = 3'd3;
    access(3, 1, 2, "R4 pair read to write");
    access(0, 1, 3, "R4 pair write to write");
    pair_rr = 3'd0;
    pair_ww = 3'd0;
    access(0, 0, model_gap(0), "R4 R5 model write to read");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule